// File: doc/BRIEF.md
# Way-Predicting Two-Way Cache Lookup

This block is the lookup path of a two-way set-associative cache. Each set keeps one prediction bit that names the way expected to hit on the next access to that set. When a request arrives, the block reads the tag, valid bit and data of the predicted way only. It compares that single tag and steers the data output from the predicted way before the compare result is known. A correct guess completes in one cycle.

When the guess is wrong, the block spends one extra cycle comparing the remaining way. It holds off new requests during that cycle. A hit there trains the set's predictor toward that way. A miss in both ways returns a response with the hit flag low and leaves the predictor as it was.

A separate fill port writes a tag and data word into a chosen way and marks it valid. It also points that set's predictor at the filled way. Refill sequencing, replacement choice and store handling live outside this block.

Top module: `wp_lookup`

## Requirements
- R1: After reset, rsp_valid is 0, req_ready is 1 and every way of every set is invalid, so the first lookup of any address misses.
- R2: The set index is the low IDX_W bits of an address and the tag is the remaining upper bits. A lookup hits only when both the set and the tag match a filled entry.
- R3: A lookup that hits in the predicted way responds in the cycle after acceptance, with rsp_hit=1, rsp_slow=0 and rsp_data equal to that way's data.
- R4: A lookup that misses the predicted way but hits the other way responds two cycles after acceptance, with rsp_hit=1, rsp_slow=1 and rsp_data equal to the other way's data.
- R5: A lookup that misses both ways responds two cycles after acceptance, with rsp_hit=0, rsp_slow=1 and rsp_data=0.
- R6: req_ready is 0 for exactly the one cycle of a second-way check. A request held during that cycle is not accepted and produces no response.
- R7: After a second-way hit, the set's predictor points at the way that hit, so a repeat of the same lookup takes the one-cycle path.
- R8: A miss in both ways leaves the set's predictor unchanged.
- R9: A fill pulse writes tag, data and valid into way fill_way of the set given by fill_addr, and sets that set's predictor to fill_way. When a fill and a predictor training hit the same set in the same cycle, the fill wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | ADDR_W | Lookup address: tag above, set index in the low bits |
| req_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | DATA_W | Data of the hitting way, 0 on a miss |
| rsp_hit | output | 1 | Lookup found a matching valid entry |
| rsp_slow | output | 1 | Response took the two-cycle path |
| fill_valid | input | 1 | Write one way this cycle |
| fill_way | input | 1 | Way to write |
| fill_addr | input | ADDR_W | Address whose set and tag are written |
| fill_data | input | DATA_W | Data word to store |

## Verification
On every cycle, the assertions check the timing contract. A fast response must follow an accepted request. A slow response must follow a stalled cycle. A stall lasts exactly one cycle, and a miss is always slow and carries zero data. The assertions also check that a predictor training lands in the set it names. The bench scenarios show the rest: which way's data comes back, and whether training takes effect on a later access. They also show that a miss leaves the guess alone and that a fill retargets the predictor. The bench checks these against a reference model of the tag, data and predictor state.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic {
        ST_LOOK   = 1'b0,
        ST_SECOND = 1'b1
    } wp_state_e;

    localparam int WP_WAYS = 2;

endpackage

// File: rtl/wp_way_array.sv
module wp_way_array #(
    parameter int SETS   = 16,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];
    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   valid_d;

    always_comb begin
        valid_d = valid_q;
        if (wr_en) begin
            valid_d[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    assign rd_tag   = tag_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];
    assign rd_data  = data_q[rd_idx];

    AST_WRITE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_idx)]) else $error("fill did not mark entry valid"); // R9

endmodule

// File: rtl/wp_pred_table.sv
module wp_pred_table #(
    parameter int SETS   = 16,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_way,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             fill_way,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_way
);

    logic [SETS-1:0] pred_q;
    logic [SETS-1:0] pred_d;

    always_comb begin
        pred_d = pred_q;
        if (upd_en) begin
            pred_d[upd_idx] = upd_way;
        end
        if (fill_en) begin
            pred_d[fill_idx] = fill_way;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_q <= '0;
        end else begin
            pred_q <= pred_d;
        end
    end

    assign rd_way = pred_q[rd_idx];

    AST_TRAIN_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !fill_en) |=> (pred_q[$past(upd_idx)] == $past(upd_way))) else $error("training lost"); // R7
    AST_FILL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (pred_q[$past(fill_idx)] == $past(fill_way))) else $error("fill did not retarget"); // R9

endmodule

// File: rtl/wp_lookup.sv
module wp_lookup
    import wp_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SETS   = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_hit,
    output logic              rsp_slow,
    input  logic              fill_valid,
    input  logic              fill_way,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data
);

    typedef struct packed {
        wp_state_e         st;
        logic [IDX_W-1:0]  idx;
        logic [TAG_W-1:0]  tag;
        logic              alt_way;
        logic              rsp_valid;
        logic              rsp_hit;
        logic              rsp_slow;
        logic [DATA_W-1:0] rsp_data;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        st:        ST_LOOK,
        idx:       '0,
        tag:       '0,
        alt_way:   1'b0,
        rsp_valid: 1'b0,
        rsp_hit:   1'b0,
        rsp_slow:  1'b0,
        rsp_data:  '0
    };

    ctl_t ctl_q, ctl_d;

    logic [IDX_W-1:0]  req_idx, fill_idx, rd_idx;
    logic [TAG_W-1:0]  req_tag, fill_tag, cmp_tag;
    logic              pred_way, rd_way, match;
    logic              upd_en, upd_way;
    logic [TAG_W-1:0]  w_tag   [WP_WAYS];
    logic              w_valid [WP_WAYS];
    logic [DATA_W-1:0] w_data  [WP_WAYS];

    assign req_idx  = req_addr[IDX_W-1:0];
    assign req_tag  = req_addr[ADDR_W-1:IDX_W];
    assign fill_idx = fill_addr[IDX_W-1:0];
    assign fill_tag = fill_addr[ADDR_W-1:IDX_W];

    assign rd_idx  = (ctl_q.st == ST_SECOND) ? ctl_q.idx : req_idx;
    assign rd_way  = (ctl_q.st == ST_SECOND) ? ctl_q.alt_way : pred_way;
    assign cmp_tag = (ctl_q.st == ST_SECOND) ? ctl_q.tag : req_tag;
    assign match   = w_valid[rd_way] && (w_tag[rd_way] == cmp_tag);

    generate
        for (genvar g = 0; g < WP_WAYS; g++) begin : g_way
            wp_way_array #(
                .SETS   (SETS),
                .TAG_W  (TAG_W),
                .DATA_W (DATA_W)
            ) u_way (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (fill_valid && (fill_way == g[0])),
                .wr_idx   (fill_idx),
                .wr_tag   (fill_tag),
                .wr_data  (fill_data),
                .rd_idx   (rd_idx),
                .rd_tag   (w_tag[g]),
                .rd_valid (w_valid[g]),
                .rd_data  (w_data[g])
            );
        end
    endgenerate

    wp_pred_table #(
        .SETS (SETS)
    ) u_pred (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (upd_en),
        .upd_idx  (ctl_q.idx),
        .upd_way  (upd_way),
        .fill_en  (fill_valid),
        .fill_idx (fill_idx),
        .fill_way (fill_way),
        .rd_idx   (rd_idx),
        .rd_way   (pred_way)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.rsp_valid = 1'b0;
        ctl_d.rsp_hit   = 1'b0;
        ctl_d.rsp_slow  = 1'b0;
        ctl_d.rsp_data  = '0;
        upd_en          = 1'b0;
        upd_way         = ctl_q.alt_way;
        case (ctl_q.st)
            ST_LOOK: begin
                if (req_valid) begin
                    if (match) begin
                        ctl_d.rsp_valid = 1'b1;
                        ctl_d.rsp_hit   = 1'b1;
                        ctl_d.rsp_data  = w_data[rd_way];
                    end else begin
                        ctl_d.st      = ST_SECOND;
                        ctl_d.idx     = req_idx;
                        ctl_d.tag     = req_tag;
                        ctl_d.alt_way = ~pred_way;
                    end
                end
            end
            ST_SECOND: begin
                ctl_d.st        = ST_LOOK;
                ctl_d.rsp_valid = 1'b1;
                ctl_d.rsp_slow  = 1'b1;
                if (match) begin
                    ctl_d.rsp_hit  = 1'b1;
                    ctl_d.rsp_data = w_data[rd_way];
                    upd_en         = 1'b1;
                end
            end
            default: ctl_d = CTL_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready = (ctl_q.st == ST_LOOK);
    assign rsp_valid = ctl_q.rsp_valid;
    assign rsp_hit   = ctl_q.rsp_hit;
    assign rsp_slow  = ctl_q.rsp_slow;
    assign rsp_data  = ctl_q.rsp_data;

    AST_FAST_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_slow) |-> $past(req_valid && req_ready)) else $error("fast response without request"); // R3
    AST_SLOW_FOLLOWS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_slow) |-> $past(!req_ready)) else $error("slow response without stall"); // R4
    AST_MISS_SLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_slow && (rsp_data == '0))) else $error("bad miss response"); // R5
    AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready) else $error("stall longer than one cycle"); // R6

endmodule

// File: tb/wp_lookup_test.sv
module wp_lookup_test;

    localparam int ADDR_W = 12;
    localparam int SETS   = 16;
    localparam int DATA_W = 32;
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_ready;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic              rsp_hit;
    logic              rsp_slow;
    logic              fill_valid = 1'b0;
    logic              fill_way = 1'b0;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic [DATA_W-1:0] fill_data = '0;

    int checks = 0;
    int errors = 0;

    logic [TAG_W-1:0]  m_tag [SETS][2];
    bit                m_val [SETS][2];
    logic [DATA_W-1:0] m_dat [SETS][2];
    bit                m_pred [SETS];

    always #2 clk = ~clk;

    wp_lookup #(.ADDR_W(ADDR_W), .SETS(SETS), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_hit(rsp_hit), .rsp_slow(rsp_slow),
        .fill_valid(fill_valid), .fill_way(fill_way), .fill_addr(fill_addr), .fill_data(fill_data)
    );

    function automatic logic [ADDR_W-1:0] mk_addr(input int tag, input int idx);
        return {tag[TAG_W-1:0], idx[IDX_W-1:0]};
    endfunction

    function automatic bit model_match(input int idx, input bit way, input logic [TAG_W-1:0] tag);
        return m_val[idx][way] && (m_tag[idx][way] == tag);
    endfunction

    task automatic check(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic do_fill(input bit way, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        int idx;
        idx = int'(a[IDX_W-1:0]);
        @(negedge clk);
        fill_valid = 1'b1; fill_way = way; fill_addr = a; fill_data = d;
        @(negedge clk);
        fill_valid = 1'b0;
        m_tag[idx][way] = a[ADDR_W-1:IDX_W];
        m_dat[idx][way] = d;
        m_val[idx][way] = 1'b1;
        m_pred[idx]     = way;
    endtask

    task automatic do_access(input logic [ADDR_W-1:0] a, input string label);
        int idx;
        logic [TAG_W-1:0] tag;
        bit p, fast, slowhit;
        string rq;
        idx     = int'(a[IDX_W-1:0]);
        tag     = a[ADDR_W-1:IDX_W];
        p       = m_pred[idx];
        fast    = model_match(idx, p, tag);
        slowhit = !fast && model_match(idx, !p, tag);
        rq = (label != "") ? label : (fast ? "R3" : (slowhit ? "R4" : "R5"));
        @(negedge clk);
        check("R6", "ready before request", {63'd0, req_ready}, 64'd1);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        if (fast) begin
            req_valid = 1'b0;
            check(rq, "rsp_valid", {63'd0, rsp_valid}, 64'd1);
            check(rq, "rsp_hit",   {63'd0, rsp_hit},   64'd1);
            check(rq, "rsp_slow",  {63'd0, rsp_slow},  64'd0);
            check(rq, "rsp_data",  {32'd0, rsp_data},  {32'd0, m_dat[idx][p]});
        end else begin
            check(rq, "no early response", {63'd0, rsp_valid}, 64'd0);
            check("R6", "ready in second cycle", {63'd0, req_ready}, 64'd0);
            req_addr = a ^ {{(ADDR_W-1){1'b0}}, 1'b1};
            @(negedge clk);
            req_valid = 1'b0;
            check(rq, "rsp_valid", {63'd0, rsp_valid}, 64'd1);
            check(rq, "rsp_slow",  {63'd0, rsp_slow},  64'd1);
            check(rq, "rsp_hit",   {63'd0, rsp_hit},   {63'd0, slowhit});
            check(rq, "rsp_data",  {32'd0, rsp_data},  slowhit ? {32'd0, m_dat[idx][!p]} : 64'd0);
            if (slowhit) m_pred[idx] = !p;
            @(negedge clk);
            check("R6", "stalled request ignored", {63'd0, rsp_valid}, 64'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int s = 0; s < SETS; s++) begin
            m_pred[s] = 1'b0;
            for (int w = 0; w < 2; w++) begin
                m_val[s][w] = 1'b0; m_tag[s][w] = '0; m_dat[s][w] = '0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
        check("R1", "req_ready after reset", {63'd0, req_ready}, 64'd1);
        do_access(mk_addr(0, 5), "R1");
        do_access(mk_addr(3, 5), "R1");

        do_fill(1'b1, mk_addr(3, 5), 32'hAAAA_0001);
        do_access(mk_addr(3, 5), "R9");
        do_access(mk_addr(3, 6), "R2");
        do_access(mk_addr(2, 5), "R2");

        do_fill(1'b0, mk_addr(7, 5), 32'hBBBB_0002);
        do_access(mk_addr(3, 5), "R4");
        do_access(mk_addr(3, 5), "R7");

        do_access(mk_addr(9, 5), "R8");
        do_access(mk_addr(3, 5), "R8");
        do_access(mk_addr(7, 5), "R4");

        for (int i = 0; i < 500; i++) begin
            int r, t, s;
            r = int'($urandom % 10);
            t = int'($urandom % 4);
            s = int'($urandom % SETS);
            if (r < 3) do_fill(1'($urandom % 2), mk_addr(t, s), $urandom);
            else       do_access(mk_addr(t, s), "");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule